// File: doc/BRIEF.md
# Pseudo-Exhaustive Multiplier Test Pattern Source

This block feeds operand pairs to an 18x18-bit multiplier under self-test. A short sequence value is split into two equal fields. Each field is tiled end to end across one 18-bit operand, so every radix-4 recode window of a Booth multiplier sees the same group pattern in the same alignment. The run length depends only on the group width, not on the operand width. Applying the vectors and compacting the responses are handled elsewhere.

A pulse on `start` launches a run. Two inputs, sampled at that moment, set the run:

- The grouping: 4-bit groups from an 8-bit sequence, giving 256 vectors, or 3-bit groups from a 6-bit sequence, giving 64 vectors.
- The sequence source: a binary count, or a maximal-length shift register.

One vector leaves per clock while `vec_valid` is high. At the end the block raises `done` and waits for the next start.

Top module: `pe_mult_tpg`

## Requirements
- R1: After reset, `vec_valid` and `done` are both low.
- R2: When `start` is high while no run is active, the first vector appears on the next clock with `vec_valid` high, and both operands are zero in that vector.
- R3: With `grp3`=0 and `lfsr_en`=0 a run has 256 vectors. Vector k has bit i of `op_a` equal to bit (i mod 4) of k, and bit i of `op_b` equal to bit 4+(i mod 4) of k. Bits 17:16 therefore repeat group bits 1:0.
- R4: With `grp3`=1 and `lfsr_en`=0 a run has 64 vectors. Vector k has bit i of `op_a` equal to bit (i mod 3) of k, and bit i of `op_b` equal to bit 3+(i mod 3) of k. This is six whole copies per operand.
- R5: During a run `vec_valid` stays high on every clock, with no gaps, and a new vector is presented each clock.
- R6: The clock after the last vector, `vec_valid` is low and `done` is high. `done` stays high until the next `start`, and `vec_valid` and `done` are never high together.
- R7: A `start` pulse during a run has no effect: the sequence continues unchanged and ends at the usual length.
- R8: With `lfsr_en`=1 the first vector is still zero. The following vectors come from a maximal-length shift register: x^8+x^6+x^5+x^4+1 for 4-bit grouping, x^6+x^5+1 for 3-bit grouping. The register is seeded with 1 after the zero vector. Operands are tiled as in R3 or R4, and every one of the 2^n sequence values appears exactly once in the 256 or 64 vectors.
- R9: `grp3` and `lfsr_en` are sampled only when a run starts. Changing them mid-run does not alter that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launches a run when idle |
| grp3 | input | 1 | 1 selects 3-bit grouping, 0 selects 4-bit grouping |
| lfsr_en | input | 1 | 1 selects the shift-register sequence, 0 selects the binary count |
| op_a | output | 18 | Multiplicand pattern |
| op_b | output | 18 | Multiplier pattern |
| vec_valid | output | 1 | Current operands form a test vector |
| done | output | 1 | Last run has finished |

## Verification
All outputs come from registers, so the first vector is due one clock after the edge that samples `start`. Each later vector is due exactly one clock after the previous one. `done` is due one clock after the last vector. The bench drives inputs on the falling edge and reads outputs on the falling edge. Each read therefore falls midway between the edge that produced the value and the edge that consumes it. Every vector index is checked in its own half-period, and the pulses for R7 and R9 are placed mid-run so that their absence of effect shows up in the vectors that follow them.

// File: rtl/pe_mult_tpg.sv
module pe_mult_tpg #(
  parameter int OP_W     = 18,
  parameter int WIDE_G   = 4,
  parameter int NARROW_G = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            grp3,
  input  logic            lfsr_en,
  output logic [OP_W-1:0] op_a,
  output logic [OP_W-1:0] op_b,
  output logic            vec_valid,
  output logic            done
);

  localparam int SEQ_W = 2 * WIDE_G;
  localparam int NW    = 2 * NARROW_G;
  localparam logic [SEQ_W-1:0] LAST_W = '1;
  localparam logic [SEQ_W-1:0] LAST_N = SEQ_W'((1 << NW) - 1);
  localparam logic [SEQ_W-1:0] TAP_W  = 8'hB8;
  localparam logic [NW-1:0]    TAP_N  = 6'h30;

  logic             running, done_q, g3_q, lf_q;
  logic [SEQ_W-1:0] seq, idx;

  wire [SEQ_W-1:0] last  = g3_q ? LAST_N : LAST_W;
  wire [SEQ_W-1:0] nxt_w = {seq[SEQ_W-2:0], ^(seq & TAP_W)};
  wire [SEQ_W-1:0] nxt_n = {{(SEQ_W-NW){1'b0}}, seq[NW-2:0], ^(seq[NW-1:0] & TAP_N)};
  wire [SEQ_W-1:0] nxt_l = (seq == '0) ? SEQ_W'(1) : (g3_q ? nxt_n : nxt_w);
  wire [SEQ_W-1:0] step  = lf_q ? nxt_l : seq + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      done_q  <= 1'b0;
      g3_q    <= 1'b0;
      lf_q    <= 1'b0;
      seq     <= '0;
      idx     <= '0;
    end else if (start && !running) begin
      running <= 1'b1;
      done_q  <= 1'b0;
      g3_q    <= grp3;
      lf_q    <= lfsr_en;
      seq     <= '0;
      idx     <= '0;
    end else if (running) begin
      if (idx == last) begin
        running <= 1'b0;
        done_q  <= 1'b1;
      end else begin
        idx <= idx + 1'b1;
        seq <= step;
      end
    end
  end

  for (genvar i = 0; i < OP_W; i++) begin : g_tile
    assign op_a[i] = g3_q ? seq[i % NARROW_G] : seq[i % WIDE_G];
    assign op_b[i] = g3_q ? seq[NARROW_G + i % NARROW_G] : seq[WIDE_G + i % WIDE_G];
  end

  assign vec_valid = running;
  assign done      = done_q;

  a_r6_excl: assert property (@(posedge clk) disable iff (!rst_n) !(vec_valid && done));
  a_r2_first_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !vec_valid) |=> (vec_valid && op_a == '0 && op_b == '0));
  a_r5_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |=> (vec_valid || done));
  a_r6_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);
  a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && start) |=> (done || op_a != '0 || op_b != '0));

endmodule

// File: tb/pe_mult_tpg_test.sv
module pe_mult_tpg_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0, start = 1'b0, grp3 = 1'b0, lfsr_en = 1'b0;
  logic [17:0] op_a, op_b;
  logic vec_valid, done;
  int checks = 0, fails = 0;

  pe_mult_tpg uut (.clk(clk), .rst_n(rst_n), .start(start), .grp3(grp3),
                   .lfsr_en(lfsr_en), .op_a(op_a), .op_b(op_b),
                   .vec_valid(vec_valid), .done(done));

  always #2.5 clk = ~clk;

  function automatic logic [17:0] tile(input logic [3:0] g, input int w);
    logic [17:0] r;
    for (int i = 0; i < 18; i++) r[i] = g[i % w];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input bit g3, input bit lf);
    int n, w;
    bit seen [256];
    logic [7:0] g;
    logic [17:0] ea, eb;
    n = g3 ? 64 : 256;
    w = g3 ? 3 : 4;
    for (int i = 0; i < 256; i++) seen[i] = 0;
    @(negedge clk);
    grp3 = g3; lfsr_en = lf; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < n; k++) begin
      chk(vec_valid === 1'b1 && done === 1'b0, "R5", {vec_valid, done}, 2'b10);
      if (lf) begin
        g = g3 ? {2'b00, op_b[2:0], op_a[2:0]} : {op_b[3:0], op_a[3:0]};
        ea = g3 ? tile({1'b0, g[2:0]}, 3) : tile(g[3:0], 4);
        eb = g3 ? tile({1'b0, g[5:3]}, 3) : tile(g[7:4], 4);
        chk(op_a === ea && op_b === eb, "R8 tiling", {op_a, op_b}, {ea, eb});
        chk(!seen[g], "R8 repeat", g, k);
        seen[g] = 1;
        if (k == 0) chk(g == 0, "R8 first", g, 0);
      end else begin
        g = 8'(k);
        ea = g3 ? tile({1'b0, g[2:0]}, 3) : tile(g[3:0], 4);
        eb = g3 ? tile({1'b0, g[5:3]}, 3) : tile(g[7:4], 4);
        chk(op_a === ea && op_b === eb, g3 ? "R4" : "R3", {op_a, op_b}, {ea, eb});
      end
      if (k == 0) chk(op_a === 0 && op_b === 0, "R2", {op_a, op_b}, 0);
      if (k == 5) begin grp3 = ~g3; lfsr_en = ~lf; end
      start = (k == 10);
      @(negedge clk);
    end
    start = 1'b0;
    grp3 = g3; lfsr_en = lf;
    chk(vec_valid === 1'b0 && done === 1'b1, "R6 end", {vec_valid, done}, 2'b01);
    repeat (3) @(negedge clk);
    chk(vec_valid === 1'b0 && done === 1'b1, "R6 sticky", {vec_valid, done}, 2'b01);
    if (lf) begin
      int cnt = 0;
      for (int i = 0; i < n; i++) if (seen[i]) cnt++;
      chk(cnt == n, "R8 coverage", cnt, n);
    end
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(vec_valid === 1'b0 && done === 1'b0, "R1", {vec_valid, done}, 2'b00);
        run(0, 0);
        run(1, 0);
        run(0, 1);
        run(1, 1);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done === 1'b0 && vec_valid === 1'b1, "R6 restart clears done", {vec_valid, done}, 2'b10);
        // R7 and R9 are covered by the mid-run pulses inside run()
      end
      begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule